// File: doc/BRIEF.md
# Two-Read One-Write General-Purpose Register Bank

This block holds the general-purpose registers of a single-cycle 32-bit RISC datapath. It has 32 entries of 32 bits each. Two read ports, each with its own 5-bit index, return register contents combinationally, so the operand fetch of an instruction needs no clock edge. One write port takes a 5-bit index, a 32-bit value and an enable. It commits on the falling clock edge. The result of one instruction therefore lands in the middle of the cycle, and the second half of that same cycle already reads the new value.

Entry 0 is a constant zero. Writes aimed at it are dropped, and both read ports return zero for index 0. A synchronous active-high reset, sampled on the same falling edge as the write port, clears every entry. Reset takes priority over a write in the same cycle.

The block has no state machine. The storage is a parameterised array of registers with one enable per entry. A write decoder drives the enables, and a generated read port is built once for each read index.

Top module: `gpr_bank2r1w`

## Requirements
- R1: A write with the enable high to any index from 1 to 31 stores the write data, and that value is then returned by any read port addressing that index until the entry is written again or reset.
- R2: Index 0 reads as all zeros on both read ports at all times. A write to index 0 is discarded, even with the enable high and nonzero data.
- R3: The two read ports are independent. Each returns the contents of the entry selected by its own index, whatever the other port's index is.
- R4: Storage changes only on a falling clock edge. With the write enable low at a falling edge, no entry changes, whatever the write index and write data are.
- R5: A read port addressing the entry being written returns the old value before the falling edge and the new value after it, within the same clock cycle.
- R6: When the reset input is high at a falling edge, every entry becomes zero after that edge. This holds even if the write enable is high in the same cycle.
- R7: When both read ports use the same index, they return identical values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; storage updates on its falling edge |
| rst | input | 1 | Synchronous active-high clear of all entries |
| rd_a_idx | input | 5 | Index for read port A |
| rd_a_data | output | 32 | Combinational contents of the entry selected by rd_a_idx |
| rd_b_idx | input | 5 | Index for read port B |
| rd_b_data | output | 32 | Combinational contents of the entry selected by rd_b_idx |
| wr_en | input | 1 | Write enable, sampled on the falling edge |
| wr_idx | input | 5 | Index of the entry to write |
| wr_data | input | 32 | Value to store |

## Verification
The only state in this block is the stored word in each entry, so a wrong internal state always appears as a wrong value on a read port. It shows up in the first half-cycle in which either port addresses the damaged entry. It does not appear before then. For that reason the bench writes every entry and reads every entry back through both ports in staggered orders, so that a misrouted enable, a wrong edge or a dropped reset surfaces within a cycle or two of the fault. Separate samples taken before and after the falling edge expose a write that lands on the wrong edge.

// File: rtl/gprf_pkg.sv
package gprf_pkg;
    localparam int GPRF_ENTRIES = 32;
    localparam int GPRF_WIDTH   = 32;
    localparam int GPRF_IDX_W   = $clog2(GPRF_ENTRIES);
    typedef logic [GPRF_IDX_W-1:0] gprf_idx_t;
    typedef logic [GPRF_WIDTH-1:0] gprf_word_t;
endpackage

// File: rtl/gprf_wr_decode.sv
module gprf_wr_decode #(
    parameter int ENTRIES = 32,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    output logic [ENTRIES-1:0] entry_we
);
    // Entry 0 never receives an enable: it is a constant.
    always_comb begin
        entry_we = '0;
        for (int i = 1; i < ENTRIES; i++) begin
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                entry_we[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/gprf_storage.sv
module gprf_storage #(
    parameter int ENTRIES = 32,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] entry_we,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  entries [ENTRIES]
);
    assign entries[0] = '0;

    for (genvar g = 1; g < ENTRIES; g++) begin : g_entry
        logic [DATA_W-1:0] word_q;
        // Falling-edge update: the first half of the cycle sets up the data,
        // and the second half reads the new contents.
        always_ff @(negedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (entry_we[g]) begin
                word_q <= wr_data;
            end
        end
        assign entries[g] = word_q;
    end
endmodule

// File: rtl/gprf_rd_port.sv
module gprf_rd_port #(
    parameter int ENTRIES = 32,
    parameter int DATA_W  = 32,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic [DATA_W-1:0] entries [ENTRIES],
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    always_comb begin
        rd_data = '0;
        for (int i = 1; i < ENTRIES; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_data = entries[i];
            end
        end
    end
endmodule

// File: rtl/gpr_bank2r1w.sv
module gpr_bank2r1w #(
    parameter int ENTRIES = gprf_pkg::GPRF_ENTRIES,
    parameter int DATA_W  = gprf_pkg::GPRF_WIDTH,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int RD_PORTS = 2;

    logic [ENTRIES-1:0] entry_we;
    logic [DATA_W-1:0]  entries [ENTRIES];
    logic [IDX_W-1:0]   port_idx  [RD_PORTS];
    logic [DATA_W-1:0]  port_data [RD_PORTS];

    gprf_wr_decode #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_dec (
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .entry_we (entry_we)
    );

    gprf_storage #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .entry_we (entry_we),
        .wr_data  (wr_data),
        .entries  (entries)
    );

    assign port_idx[0] = rd_a_idx;
    assign port_idx[1] = rd_b_idx;

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        gprf_rd_port #(.ENTRIES(ENTRIES), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_rd (
            .entries (entries),
            .rd_idx  (port_idx[p]),
            .rd_data (port_data[p])
        );
    end

    assign rd_a_data = port_data[0];
    assign rd_b_data = port_data[1];
endmodule

// File: rtl/gprf_checker.sv
module gprf_checker #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic [IDX_W-1:0]  rd_a_idx,
    input logic [DATA_W-1:0] rd_a_data,
    input logic [IDX_W-1:0]  rd_b_idx,
    input logic [DATA_W-1:0] rd_b_data,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [DATA_W-1:0] wr_data
);
    assert_zero_a_R2: assert property (@(negedge clk) disable iff (rst)
        (rd_a_idx == '0) |-> (rd_a_data == '0));

    assert_zero_b_R2: assert property (@(negedge clk) disable iff (rst)
        (rd_b_idx == '0) |-> (rd_b_data == '0));

    assert_same_index_R7: assert property (@(negedge clk) disable iff (rst)
        (rd_a_idx == rd_b_idx) |-> (rd_a_data == rd_b_data));

    assert_write_lands_R1: assert property (@(negedge clk) disable iff (rst)
        (wr_en && wr_idx != '0) |=>
        ((rd_a_idx != $past(wr_idx)) || (rd_a_data == $past(wr_data))));

    assert_idle_holds_R4: assert property (@(negedge clk) disable iff (rst)
        (!wr_en) |=> (!$stable(rd_b_idx) || $stable(rd_b_data)));

    assert_reset_clears_R6: assert property (@(negedge clk)
        rst |=> ((rd_a_data == '0) && (rd_b_data == '0)));
endmodule

bind gpr_bank2r1w gprf_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_a_idx  (rd_a_idx),
    .rd_a_data (rd_a_data),
    .rd_b_idx  (rd_b_idx),
    .rd_b_data (rd_b_data),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data)
);

// File: tb/sim_gpr_bank2r1w.sv
`timescale 1ns/1ps
module sim_gpr_bank2r1w;
    localparam int N = 32;

    typedef struct {
        logic [31:0] exp_a;
        logic [31:0] exp_b;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
    logic        wr_en = 1'b0;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [N];
    item_t sb [$];

    always #4 clk = ~clk;

    gpr_bank2r1w u0 (
        .clk(clk), .rst(rst),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    // Driver: applies one cycle of stimulus and predicts the port values
    // after that cycle's falling edge.
    task automatic drive(input bit r, input bit w, input int wi, input logic [31:0] wd,
                         input int a, input int b, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        rst = r; wr_en = w; wr_idx = 5'(wi); wr_data = wd;
        rd_a_idx = 5'(a); rd_b_idx = 5'(b);
        if (r) begin
            for (int i = 0; i < N; i++) model[i] = '0;
        end else if (w && wi != 0) begin
            model[wi] = wd;
        end
        it.exp_a = model[a];
        it.exp_b = model[b];
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: sampled in the second half of each cycle.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (rd_a_data !== it.exp_a || rd_b_data !== it.exp_b) begin
                    errors++;
                    $display("FAIL %s: A=%h B=%h expected A=%h B=%h",
                             it.tag, rd_a_data, rd_b_data, it.exp_a, it.exp_b);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] old_v;
        for (int i = 0; i < N; i++) model[i] = 'x;
        // R6: reset state on every entry, write enable ignored under reset
        drive(1'b1, 1'b1, 9, 32'h1234_5678, 9, 0, "R6 reset with write");
        for (int i = 0; i < N; i++) drive(1'b0, 1'b0, 0, '0, i, N - 1 - i, "R6 reset state");
        // R1/R5: fill entries, each read back in the same cycle as its write
        for (int i = 1; i < N; i++)
            drive(1'b0, 1'b1, i, 32'hA500_0000 ^ (i * 32'h0101_0011), i, i - 1, "R1 R5 write-through");
        // R2: write to entry 0 is discarded
        drive(1'b0, 1'b1, 0, 32'hFFFF_FFFF, 0, 0, "R2 zero entry write");
        drive(1'b0, 1'b0, 0, '0, 0, 1, "R2 zero entry read");
        // R4: disabled write leaves entry alone
        drive(1'b0, 1'b0, 5, 32'hDEAD_BEEF, 5, 6, "R4 disabled write");
        drive(1'b0, 1'b0, 0, '0, 5, 5, "R4 after disabled write");
        // R3: independent indices in crossing orders
        for (int i = 0; i < N; i++) drive(1'b0, 1'b0, 0, '0, i, (i * 7 + 3) % N, "R3 independent ports");
        // R7: equal indices
        for (int i = 0; i < N; i += 5) drive(1'b0, 1'b0, 0, '0, i, i, "R7 same index");
        // R5: before the falling edge the old value is seen
        old_v = model[7];
        drive(1'b0, 1'b1, 7, 32'h0BAD_F00D, 7, 8, "R5 after edge");
        #2;
        checks++;
        if (rd_a_data !== old_v) begin
            errors++;
            $display("FAIL R5 before edge: A=%h expected=%h", rd_a_data, old_v);
        end
        // R1: overwrite then read from port B
        drive(1'b0, 1'b1, 31, 32'h8000_0001, 30, 31, "R1 overwrite");
        // R6: reset mid-run with write asserted clears everything
        drive(1'b1, 1'b1, 12, 32'h5555_AAAA, 12, 31, "R6 mid-run reset");
        for (int i = 0; i < N; i += 3) drive(1'b0, 1'b0, 0, '0, i, i + 1, "R6 cleared after reset");
        drive(1'b0, 1'b0, 0, '0, 0, 0, "idle");
        repeat (3) @(posedge clk);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule